// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a complete leaf page table entry by reading a two-level table held in memory. A request carries a 20-bit virtual page number. The walker takes the root table page from a base input and reads one word from the first-level table. If that word is marked present, it names the page that holds the second-level table. The walker then reads one word from that table and returns the leaf entry, ready to be written into a translation cache. The caller forms the final physical address by joining the leaf's page number (bits 31..12) with its own untouched 12-bit page offset.

If either entry has its valid bit clear, the walk ends with a page-fault pulse that names the level where it stopped. A first-level miss ends the walk before any second-level read is issued. Memory is reached through a single word-read port. A request is handed over with a valid/ready handshake, and the response comes back some cycles later, marked by a response-valid strobe.

The controller has seven states. IDLE is the only state that accepts a walk. It moves to RD1, which presents the first-level read. Once the read is accepted, the walker moves to WT1 and waits for the response. From WT1, a present entry leads to RD2 and then WT2. A missing entry in WT1 or WT2 leads to FAULT. A present leaf in WT2 leads to DONE. DONE and FAULT each last one cycle and then return to IDLE.

Top module: `pgwalk_two_level`

## Requirements
- R1: Out of reset, `walk_ready` is 1, and `mem_req_valid`, `done_valid` and `fault_valid` are all 0.
- R2: A walk is accepted only while `walk_ready` is high. `walk_ready` is high only in IDLE. A request presented during a walk is ignored, and the running walk completes with its own result.
- R3: The first read address is `{root_ppn, 12'h000} + 4 * walk_vpn[19:10]`. Here `root_ppn` is the value sampled when the walk was accepted.
- R4: The second read address is `{E1[31:12], 12'h000} + 4 * walk_vpn[9:0]`, where E1 is the first-level word that was read.
- R5: Entry layout: bit 0 is valid, bit 1 write, bit 2 read, bit 3 user, bit 4 exec, and bits 31..12 the page number. On success, `done_pte` equals the second-level word bit for bit, with `done_valid` high.
- R6: A first-level word with bit 0 clear gives `fault_valid` with `fault_level` = 1. No second read is issued.
- R7: A second-level word with bit 0 clear gives `fault_valid` with `fault_level` = 2.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change on the next cycle.
- R9: The walker waits any number of cycles for `mem_req_ready` and for `mem_rsp_valid`. The result does not depend on these delays.
- R10: `done_valid` and `fault_valid` each stay high for exactly one cycle and are never high together. On the cycle after either pulse, `walk_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | 20 | Page number of the first-level table |
| walk_valid | input | 1 | Walk request strobe |
| walk_vpn | input | 20 | Virtual page number to translate |
| walk_ready | output | 1 | Walker idle, request taken this cycle if valid |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| done_valid | output | 1 | One-cycle pulse: translation found |
| done_pte | output | 32 | Leaf entry returned on success |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 2 | Level (1 or 2) of the missing entry |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 12-bit page offset, 10-bit indices per level and 4-byte entries. This makes the extreme indices 0 and 0x3FF at both levels reachable, as well as table pages near the top of the physical space where the address addition must not carry into the wrong field. The bench's behavioural memory has adjustable response latency and a periodic ready stall. These two settings let the same walks be repeated under back-pressure, so the held request and the variable waits are exercised without any change to the walker.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD1,
        S_WT1,
        S_RD2,
        S_WT2,
        S_DONE,
        S_FAULT
    } walk_state_e;

    localparam int PTE_PRESENT_BIT = 0;

endpackage

// File: rtl/pgwalk_entry_addr.sv
module pgwalk_entry_addr #(
    parameter int PA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int IDX_W   = 10,
    parameter int ESZ_LOG = 2,
    localparam int PPN_W  = PA_W - OFS_W
) (
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);

    logic [PA_W-1:0] table_base;
    logic [PA_W-1:0] idx_bytes;

    always_comb begin
        table_base = {base_ppn, {OFS_W{1'b0}}};
        idx_bytes  = PA_W'(idx) << ESZ_LOG;
        addr       = table_base + idx_bytes;
    end

endmodule

// File: rtl/pgwalk_pte_fields.sv
module pgwalk_pte_fields
    import pgwalk_pkg::*;
#(
    parameter int PTE_W  = 32,
    parameter int OFS_W  = 12,
    parameter int PPN_W  = 20
) (
    input  logic [PTE_W-1:0] pte,
    output logic             present,
    output logic [PPN_W-1:0] next_ppn
);

    logic unused_attr;

    assign present     = pte[PTE_PRESENT_BIT];
    assign next_ppn    = pte[OFS_W +: PPN_W];
    assign unused_attr = ^pte[OFS_W-1:1];

endmodule

// File: rtl/pgwalk_two_level.sv
module pgwalk_two_level
    import pgwalk_pkg::*;
#(
    parameter int PA_W   = 32,
    parameter int OFS_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PTE_W  = 32,
    localparam int PPN_W   = PA_W - OFS_W,
    localparam int VPN_W   = 2 * IDX_W,
    localparam int ESZ_LOG = $clog2(PTE_W / 8),
    localparam int LEVELS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             walk_valid,
    input  logic [VPN_W-1:0] walk_vpn,
    output logic             walk_ready,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic [PTE_W-1:0] done_pte,
    output logic             fault_valid,
    output logic [1:0]       fault_level
);

    walk_state_e state_q, state_d;

    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] l2base_q;
    logic [PTE_W-1:0] pte_q;
    logic [1:0]       flvl_q;

    logic [LEVELS-1:0][PPN_W-1:0] lvl_base;
    logic [LEVELS-1:0][IDX_W-1:0] lvl_idx;
    logic [LEVELS-1:0][PA_W-1:0]  lvl_addr;

    logic             rsp_present;
    logic [PPN_W-1:0] rsp_ppn;

    assign lvl_base[0] = root_q;
    assign lvl_base[1] = l2base_q;
    assign lvl_idx[0]  = vpn_q[VPN_W-1 -: IDX_W];
    assign lvl_idx[1]  = vpn_q[IDX_W-1:0];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pgwalk_entry_addr #(
            .PA_W   (PA_W),
            .OFS_W  (OFS_W),
            .IDX_W  (IDX_W),
            .ESZ_LOG(ESZ_LOG)
        ) u_addr (
            .base_ppn(lvl_base[g]),
            .idx     (lvl_idx[g]),
            .addr    (lvl_addr[g])
        );
    end

    pgwalk_pte_fields #(
        .PTE_W(PTE_W),
        .OFS_W(OFS_W),
        .PPN_W(PPN_W)
    ) u_fields (
        .pte     (mem_rsp_data),
        .present (rsp_present),
        .next_ppn(rsp_ppn)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (walk_valid)    state_d = S_RD1;
            S_RD1:   if (mem_req_ready) state_d = S_WT1;
            S_WT1:   if (mem_rsp_valid) state_d = rsp_present ? S_RD2 : S_FAULT;
            S_RD2:   if (mem_req_ready) state_d = S_WT2;
            S_WT2:   if (mem_rsp_valid) state_d = rsp_present ? S_DONE : S_FAULT;
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // walk context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q    <= '0;
            root_q   <= '0;
            l2base_q <= '0;
            pte_q    <= '0;
            flvl_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (walk_valid) begin
                    vpn_q  <= walk_vpn;
                    root_q <= root_ppn;
                end
                S_WT1: if (mem_rsp_valid) begin
                    if (rsp_present) l2base_q <= rsp_ppn;
                    else             flvl_q   <= 2'd1;
                end
                S_WT2: if (mem_rsp_valid) begin
                    if (rsp_present) pte_q  <= mem_rsp_data;
                    else             flvl_q <= 2'd2;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        walk_ready    = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_RD1) || (state_q == S_RD2);
        mem_req_addr  = (state_q == S_RD2) ? lvl_addr[1] : lvl_addr[0];
        done_valid    = (state_q == S_DONE);
        fault_valid   = (state_q == S_FAULT);
        done_pte      = pte_q;
        fault_level   = flvl_q;
    end

endmodule

// File: rtl/pgwalk_two_level_chk.sv
module pgwalk_two_level_chk #(
    parameter int PA_W  = 32,
    parameter int PTE_W = 32,
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             walk_valid,
    input logic             walk_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             done_valid,
    input logic [PTE_W-1:0] done_pte,
    input logic             fault_valid,
    input logic [1:0]       fault_level
);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && walk_ready |=> !walk_ready);

    // R5
    leaf_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_pte[0]);

    // R6
    fault_level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_level == 2'd1) || (fault_level == 2'd2));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && walk_ready);

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid && walk_ready);

    // R10
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

endmodule

bind pgwalk_two_level pgwalk_two_level_chk #(
    .PA_W (PA_W),
    .PTE_W(PTE_W),
    .VPN_W(VPN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .walk_valid   (walk_valid),
    .walk_ready   (walk_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .done_valid   (done_valid),
    .done_pte     (done_pte),
    .fault_valid  (fault_valid),
    .fault_level  (fault_level)
);

// File: tb/pgwalk_two_level_tb.sv
module pgwalk_two_level_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_ppn = 20'h00123;
    logic        walk_valid = 1'b0;
    logic [19:0] walk_vpn = '0;
    logic        walk_ready;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_pte;
    logic        fault_valid;
    logic [1:0]  fault_level;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pgwalk_two_level u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .root_ppn     (root_ppn),
        .walk_valid   (walk_valid),
        .walk_vpn     (walk_vpn),
        .walk_ready   (walk_ready),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .done_valid   (done_valid),
        .done_pte     (done_pte),
        .fault_valid  (fault_valid),
        .fault_level  (fault_level)
    );

    // behavioural memory
    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          stall = 0;
    int          cyc = 0;
    logic        rdy_q = 1'b1;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    int          req_cnt = 0;
    logic [31:0] req_log [0:255];

    assign mem_req_ready = rdy_q;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rdy_q <= (stall == 0) || ((cyc % (stall + 1)) == stall);
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            req_log[req_cnt[7:0]] <= mem_req_addr;
            req_cnt <= req_cnt + 1;
            pend    <= 1'b1;
            cnt     <= lat;
            paddr   <= mem_req_addr;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(paddr);
                pend <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // generic walk: sets tables, runs, checks against the requirements
    task automatic walk_case(input logic [19:0] vpn, input logic [31:0] e1, input logic [31:0] e2,
                             input bit busy_poke);
        logic [31:0] a1, a2;
        int base;
        bit got_d, got_f;
        logic [31:0] got_pte;
        logic [1:0]  got_lvl;
        a1 = {root_ppn, 12'h000} + {20'h0, vpn[19:10], 2'b00};
        a2 = {e1[31:12], 12'h000} + {20'h0, vpn[9:0], 2'b00};
        mem[a1] = e1;
        if (e1[0]) mem[a2] = e2;
        got_d = 0; got_f = 0; got_pte = '0; got_lvl = '0;
        @(negedge clk);
        base = req_cnt;
        walk_valid = 1'b1;
        walk_vpn   = vpn;
        @(negedge clk);
        if (busy_poke) walk_vpn = vpn ^ 20'hFFC00;
        else           walk_valid = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if (done_valid || fault_valid) begin
                got_d = done_valid; got_f = fault_valid;
                got_pte = done_pte; got_lvl = fault_level;
                break;
            end
            @(negedge clk);
        end
        walk_valid = 1'b0;
        // R3: first address
        chk(req_log[base[7:0]] == a1, "R3 level-1 address", req_log[base[7:0]], a1);
        if (!e1[0]) begin
            // R6
            chk(got_f && !got_d, "R6 fault pulse", {31'h0, got_f}, 32'h1);
            chk(got_lvl == 2'd1, "R6 fault level", {30'h0, got_lvl}, 32'h1);
            chk(req_cnt - base == 1, "R6 no level-2 read", req_cnt - base, 32'h1);
        end else begin
            // R4
            chk(req_log[(base + 1) % 256] == a2, "R4 level-2 address", req_log[(base + 1) % 256], a2);
            chk(req_cnt - base == 2, "R4 read count", req_cnt - base, 32'h2);
            if (!e2[0]) begin
                // R7
                chk(got_f && !got_d, "R7 fault pulse", {31'h0, got_f}, 32'h1);
                chk(got_lvl == 2'd2, "R7 fault level", {30'h0, got_lvl}, 32'h2);
            end else begin
                // R5
                chk(got_d && !got_f, "R5 done pulse", {31'h0, got_d}, 32'h1);
                chk(got_pte == e2, "R5 leaf entry", got_pte, e2);
            end
        end
        @(negedge clk);
        // R10
        chk(!done_valid && !fault_valid, "R10 pulse width", {30'h0, done_valid, fault_valid}, 32'h0);
        chk(walk_ready, "R10 back to idle", {31'h0, walk_ready}, 32'h1);
    endtask

    task automatic t_reset;
        // R1
        chk(walk_ready, "R1 walk_ready", {31'h0, walk_ready}, 32'h1);
        chk(!mem_req_valid && !done_valid && !fault_valid, "R1 outputs idle",
            {29'h0, mem_req_valid, done_valid, fault_valid}, 32'h0);
    endtask

    task automatic t_basic_hit;
        lat = 0; stall = 0;
        walk_case({10'h001, 10'h002}, 32'h0045600D, 32'hABCDE017, 1'b0);
    endtask

    task automatic t_stall_extremes;
        // R8 R9: back-pressure and slow responses, top indices
        lat = 5; stall = 3;
        walk_case({10'h3FF, 10'h3FF}, 32'hFFFFF003, 32'h12345005, 1'b0);
        walk_case({10'h000, 10'h000}, 32'h00800001, 32'hFEDCB01F, 1'b0);
        lat = 0; stall = 0;
    endtask

    task automatic t_l1_fault;
        lat = 2; stall = 1;
        walk_case({10'h155, 10'h0AA}, 32'h0077701E, 32'h0, 1'b0);
        lat = 0; stall = 0;
    endtask

    task automatic t_l2_fault;
        lat = 1; stall = 0;
        walk_case({10'h0F0, 10'h00F}, 32'h00999001, 32'h55555FFE, 1'b0);
    endtask

    task automatic t_busy_ignore;
        // R2: a second request held during the walk is ignored
        lat = 3; stall = 2;
        walk_case({10'h010, 10'h020}, 32'h00321001, 32'h0BEEF011, 1'b1);
        lat = 0; stall = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_hit();
        t_stall_extremes();
        t_l1_fault();
        t_l2_fault();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule